// File: doc/BRIEF.md
# Chroma Subsampler for Component Video

This block converts a pixel stream with full chroma resolution into a stream with half the chroma rate. Each pixel arrives as three parallel samples: luma on the green channel, Pb on the blue channel and Pr on the red channel. Each pixel comes with a valid strobe and a marker for the first pixel of a line. In subsampled mode, luma goes out on every pixel. The red output bus carries alternating chroma samples, starting with Pb. The blue output bus is forced to zero. In bypass mode all three channels are passed through untouched.

Two chroma orderings are supported. In the paired ordering, both chroma samples come from the even pixel (U0 V0 U2 V2). For this the Pr of an even pixel is held for one pixel and sent out on the next odd pixel. In the staggered ordering, Pb comes from the even pixel and Pr from the odd pixel (U0 V1 U2 V3). Both mode bits are sampled only at a line start, so a line is never split between modes. Chroma is selected without any filtering.

Top module: `chroma_subsampler`

## Requirements
- R1: While reset is asserted, and on the first sample point after it is released, `outValid` is 0 and all three output buses are 0.
- R2: Every input pixel with `inValid` high appears on the outputs exactly one clock later with `outValid` high. `outValid` is low in the cycle after an idle input cycle.
- R3: In bypass mode (subsample bit 0), the green, blue and red output buses equal the luma, Pb and Pr inputs of the pixel.
- R4: In subsampled mode (subsample bit 1), the green output bus carries the luma of every pixel.
- R5: In subsampled mode, the blue output bus is all zeros on every pixel.
- R6: In subsampled mode with the order bit 0 (paired), an even pixel puts its own Pb on the red bus. An odd pixel puts the Pr of the preceding even pixel on the red bus.
- R7: In subsampled mode with the order bit 1 (staggered), an even pixel puts its own Pb on the red bus. An odd pixel puts its own Pr on the red bus.
- R8: A valid pixel with `inLineStart` high is an even pixel (index 0). The even/odd phase advances only on valid pixels, so idle cycles inside a line do not shift it.
- R9: Both mode bits are sampled only on a valid pixel with `inLineStart` high, and they apply from that pixel on. A change at any other time has no effect until the next line start.
- R10: In a cycle after an idle input cycle, all three output buses keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel valid |
| inLineStart | input | 1 | Marks the first pixel of a line |
| inLuma | input | DATA_W | Luma sample (green channel) |
| inCb | input | DATA_W | Pb sample (blue channel) |
| inCr | input | DATA_W | Pr sample (red channel) |
| cfgSubsample | input | 1 | 1 = subsampled output, 0 = bypass |
| cfgStagger | input | 1 | 1 = staggered chroma order, 0 = paired |
| outValid | output | 1 | Output pixel valid |
| outGreenBus | output | DATA_W | Luma output |
| outBlueBus | output | DATA_W | Pb in bypass, zero in subsampled mode |
| outRedBus | output | DATA_W | Pr in bypass, alternating chroma in subsampled mode |

## Verification
The bench builds the block with the default `DATA_W` of 8. Every sample byte of a pixel is distinct and derived from the pixel index, so a chroma sample taken from the wrong pixel or the wrong channel shows up as a wrong value. Within this width the bench sends lines of odd and even length, idle gaps inside a line, and mode changes both in the middle of a line and at a line start. This exercises phase restart, phase freeze during gaps and mode latching in both chroma orderings.

// File: rtl/subsamp_pkg.sv
package subsamp_pkg;
  typedef struct packed {
    logic load;
    logic subsample;
    logic stagger;
    logic oddPhase;
  } subsampStrb_t;
endpackage

// File: rtl/subsamp_ctrl.sv
module subsamp_ctrl
  import subsamp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inLineStart,
  input  logic         cfgSubsample,
  input  logic         cfgStagger,
  output subsampStrb_t strb
);
  logic lineBegin;
  logic subReg;
  logic stagReg;
  logic phaseReg;

  assign lineBegin = inValid & inLineStart;

  always_comb begin
    strb.load      = inValid;
    strb.subsample = lineBegin ? cfgSubsample : subReg;
    strb.stagger   = lineBegin ? cfgStagger   : stagReg;
    strb.oddPhase  = lineBegin ? 1'b0         : phaseReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subReg   <= 1'b0;
      stagReg  <= 1'b0;
      phaseReg <= 1'b0;
    end else begin
      if (lineBegin) begin
        subReg  <= cfgSubsample;
        stagReg <= cfgStagger;
      end
      if (inValid) phaseReg <= ~strb.oddPhase;
    end
  end

  assert_line_even_R8: assert property (@(posedge clk) disable iff (!rstN)
    lineBegin |-> !strb.oddPhase);
  assert_phase_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(phaseReg));
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !lineBegin |=> ($stable(subReg) && $stable(stagReg)));
endmodule

// File: rtl/subsamp_datapath.sv
module subsamp_datapath
  import subsamp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  subsampStrb_t      strb,
  input  logic [DATA_W-1:0] inLuma,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  output logic              outValid,
  output logic [DATA_W-1:0] outGreen,
  output logic [DATA_W-1:0] outBlue,
  output logic [DATA_W-1:0] outRed
);
  logic [DATA_W-1:0] heldCr;
  logic [DATA_W-1:0] nextBlue;
  logic [DATA_W-1:0] nextRed;

  always_comb begin
    nextBlue = strb.subsample ? '0 : inCb;
    if (!strb.subsample)    nextRed = inCr;
    else if (!strb.oddPhase) nextRed = inCb;
    else if (strb.stagger)   nextRed = inCr;
    else                     nextRed = heldCr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outGreen <= '0;
      outBlue  <= '0;
      outRed   <= '0;
      heldCr   <= '0;
    end else begin
      outValid <= strb.load;
      if (strb.load) begin
        outGreen <= inLuma;
        outBlue  <= nextBlue;
        outRed   <= nextRed;
        if (!strb.oddPhase) heldCr <= inCr;
      end
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outValid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !outValid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(outGreen) && $stable(outBlue) && $stable(outRed)));
  assert_luma_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (outGreen == $past(inLuma)));
  assert_blue_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.subsample) |=> (outBlue == '0));
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.subsample) |=> (outBlue == $past(inCb) && outRed == $past(inCr)));
  assert_even_cb_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.subsample && !strb.oddPhase) |=> (outRed == $past(inCb)));
endmodule

// File: rtl/chroma_subsampler.sv
module chroma_subsampler
  import subsamp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inLineStart,
  input  logic [DATA_W-1:0] inLuma,
  input  logic [DATA_W-1:0] inCb,
  input  logic [DATA_W-1:0] inCr,
  input  logic              cfgSubsample,
  input  logic              cfgStagger,
  output logic              outValid,
  output logic [DATA_W-1:0] outGreenBus,
  output logic [DATA_W-1:0] outBlueBus,
  output logic [DATA_W-1:0] outRedBus
);
  subsampStrb_t strb;

  subsamp_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inLineStart  (inLineStart),
    .cfgSubsample (cfgSubsample),
    .cfgStagger   (cfgStagger),
    .strb         (strb)
  );

  subsamp_datapath #(.DATA_W(DATA_W)) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inLuma   (inLuma),
    .inCb     (inCb),
    .inCr     (inCr),
    .outValid (outValid),
    .outGreen (outGreenBus),
    .outBlue  (outBlueBus),
    .outRed   (outRedBus)
  );
endmodule

// File: tb/chroma_subsampler_tb_top.sv
module chroma_subsampler_tb_top;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inLineStart = 1'b0;
  logic [DATA_W-1:0] inLuma = '0;
  logic [DATA_W-1:0] inCb = '0;
  logic [DATA_W-1:0] inCr = '0;
  logic cfgSubsample = 1'b0;
  logic cfgStagger = 1'b0;
  logic outValid;
  logic [DATA_W-1:0] outGreenBus, outBlueBus, outRedBus;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // expected outputs for the pixel most recently driven
  logic expValid = 1'b0;
  logic [DATA_W-1:0] expG = '0, expB = '0, expR = '0;
  string tagG = "R1", tagB = "R1", tagR = "R1", tagV = "R1", expScen = "reset";
  // model state derived from the requirements
  logic mSub = 1'b0, mStag = 1'b0, mPhase = 1'b0;
  logic [DATA_W-1:0] mHeld = '0;

  always #10ns clk = ~clk;

  chroma_subsampler #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLineStart(inLineStart),
    .inLuma(inLuma), .inCb(inCb), .inCr(inCr),
    .cfgSubsample(cfgSubsample), .cfgStagger(cfgStagger),
    .outValid(outValid), .outGreenBus(outGreenBus),
    .outBlueBus(outBlueBus), .outRedBus(outRedBus)
  );

  task automatic compare(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                         input string tag, input string what, input string scen);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s (%s): actual %0h expected %0h", tag, what, scen, act, exp);
    end
  endtask

  task automatic checkOutputs();
    compare({{(DATA_W-1){1'b0}}, outValid}, {{(DATA_W-1){1'b0}}, expValid}, tagV, "valid", expScen);
    compare(outGreenBus, expG, tagG, "green", expScen);
    compare(outBlueBus, expB, tagB, "blue", expScen);
    compare(outRedBus, expR, tagR, "red", expScen);
  endtask

  // At a falling edge: check the previous pixel's outputs, then drive the next.
  task automatic pushPixel(input logic v, input logic ls, input int idx, input string scen);
    logic odd;
    logic [DATA_W-1:0] y, cb, cr;
    @(negedge clk);
    checkOutputs();
    y  = DATA_W'(8'h10 + idx);
    cb = DATA_W'(8'h50 + idx);
    cr = DATA_W'(8'hA0 + idx);
    inValid = v; inLineStart = ls; inLuma = y; inCb = cb; inCr = cr;
    expScen = scen;
    if (v) begin
      if (ls) begin
        mSub = cfgSubsample; mStag = cfgStagger; odd = 1'b0;
      end else begin
        odd = mPhase;
      end
      mPhase = ~odd;
      expValid = 1'b1; tagV = "R2";
      expG = y;
      if (!mSub) begin
        expB = cb; expR = cr; tagG = "R3"; tagB = "R3"; tagR = "R3";
      end else begin
        expB = '0; tagG = "R4"; tagB = "R5";
        if (!odd) begin expR = cb; tagR = mStag ? "R7" : "R6"; end
        else if (mStag) begin expR = cr; tagR = "R7"; end
        else begin expR = mHeld; tagR = "R6"; end
      end
      if (!odd) mHeld = cr;
    end else begin
      expValid = 1'b0; tagV = "R2";
      tagG = "R10"; tagB = "R10"; tagR = "R10";
    end
  endtask

  task automatic runReset();
    // R1: outputs at zero while reset is held and just after release
    repeat (3) @(negedge clk);
    expScen = "reset held";
    checkOutputs();
    rstN = 1'b1;
    @(negedge clk);
    expScen = "after reset R1";
    checkOutputs();
  endtask

  task automatic runBypass();
    cfgSubsample = 1'b0; cfgStagger = 1'b0;
    for (int i = 0; i < 6; i++) pushPixel(1'b1, i == 0, i, "bypass R3");
  endtask

  task automatic runPairedWithGaps();
    // R6 with idle gaps: R8 phase freeze, R10 hold
    cfgSubsample = 1'b1; cfgStagger = 1'b0;
    for (int i = 0; i < 6; i++) begin
      pushPixel(1'b1, i == 0, 20 + i, "paired R6 R8");
      if (i == 2 || i == 3) begin
        pushPixel(1'b0, 1'b0, 40 + i, "gap R10");
        pushPixel(1'b0, 1'b0, 50 + i, "gap R10");
      end
    end
  endtask

  task automatic runStaggered();
    cfgSubsample = 1'b1; cfgStagger = 1'b1;
    for (int i = 0; i < 6; i++) pushPixel(1'b1, i == 0, 60 + i, "staggered R7");
  endtask

  task automatic runMidLineConfig();
    // R9: mid-line change ignored, taken at next line start
    cfgSubsample = 1'b1; cfgStagger = 1'b0;
    pushPixel(1'b1, 1'b1, 80, "midline R9");
    pushPixel(1'b1, 1'b0, 81, "midline R9");
    cfgSubsample = 1'b0; cfgStagger = 1'b1;
    for (int i = 2; i < 6; i++) pushPixel(1'b1, 1'b0, 80 + i, "midline R9");
    cfgSubsample = 1'b1;
    pushPixel(1'b0, 1'b1, 90, "idle line start R9");
    for (int i = 0; i < 4; i++) pushPixel(1'b1, i == 0, 100 + i, "new line R9");
  endtask

  task automatic runOddLengthRestart();
    // R8: a line of odd length, then a restart must begin with Pb
    cfgSubsample = 1'b1; cfgStagger = 1'b0;
    for (int i = 0; i < 3; i++) pushPixel(1'b1, i == 0, 120 + i, "odd line R8");
    for (int i = 0; i < 4; i++) pushPixel(1'b1, i == 0, 130 + i, "restart R8");
    pushPixel(1'b0, 1'b0, 0, "flush R2");
    pushPixel(1'b0, 1'b0, 0, "flush R10");
  endtask

  initial begin
    runReset();
    runBypass();
    runPairedWithGaps();
    runStaggered();
    runMidLineConfig();
    runOddLengthRestart();
    @(negedge clk);
    checkOutputs();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule